// File: doc/BRIEF.md
# Highest-Active-Core Slot Arbiter

This block decides, cycle by cycle, which core owns the shared memory port. A slot counter advances once per clock and its value is the granted core index. In the default fixed mode the counter walks every core slot in turn, so each core gets the port once per full rotation whatever else is running.

In the top-tracking mode the rotation is cut short. It wraps just after the highest-numbered core whose active bit is set, so any rotation length from one slot up to the full count is possible, not only powers of two. The lower cores then get the port more often.

A core that needs exact full-rotation timing keeps that timing in one of two ways: the highest core stays active, or the mode flag stays clear. The mode flag is sampled only when the counter wraps to slot 0, so a rotation is never truncated by a mode change. Changes to the active vector act at once.

Top module: `hub_topcore_arbiter`

## Requirements
- R1: While `rst` is high the granted index is 0 and the arbiter is in fixed mode. After release the index steps 1, 2, 3 … on successive clocks.
- R2: In fixed mode the index counts 0 to NCORES-1 and wraps to 0, whatever pattern the nonzero active vector holds.
- R3: In top-tracking mode the index wraps to 0 on the clock after it equals the highest set bit position of `active_i`. This gives a rotation length of that position plus one, for example 1, 3, 6 or 10.
- R4: In top-tracking mode, a top active core at position 7 gives an 8-slot rotation, and a top core at position 15 gives the full 16-slot rotation.
- R5: If the active vector drops the top below the current index, `grant_valid_o` goes low in that same cycle and the index returns to 0 on the next clock.
- R6: `enable_i` (1 = top-tracking, 0 = fixed) is taken only on the clock where the index wraps to 0. A change made mid-rotation leaves the current rotation length untouched.
- R7: With an all-zero active vector, `grant_valid_o` is low in both modes.
- R8: `grant_valid_o` is high whenever the active vector is nonzero and the index is within the current rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| active_i | input | NCORES | One bit per core, 1 = core running |
| enable_i | input | 1 | 1 selects top-tracking rotation, 0 the fixed full rotation |
| grant_idx_o | output | IDXW | Core index owning the current slot |
| grant_valid_o | output | 1 | Current slot grant is usable |

## Verification
The bench walks rotation lengths of 1, 3, 4, 6, 7, 8, 10, 15 and 16. An encoder that picked the lowest set bit, or rounded up to a power of two, would produce the wrong wrap point at these lengths.

It flips the mode flag mid-rotation in both directions. A design that applied the flag at once would cut the rotation short or stretch it.

It also lowers the top core while the counter sits above it. A design that kept counting up to the full width would grant slots that are no longer in the rotation.

An all-zero active vector is applied in both modes. A design that still raised the valid flag would be caught there.

// File: rtl/hsa_pkg.sv
package hsa_pkg;
    localparam int unsigned DEF_CORES = 16;

    typedef enum logic {
        ROT_FIXED = 1'b0,
        ROT_TOP   = 1'b1
    } rot_mode_e;

    function automatic rot_mode_e mode_from_flag(input logic flag);
        return flag ? ROT_TOP : ROT_FIXED;
    endfunction
endpackage

// File: rtl/hsa_top_encoder.sv
module hsa_top_encoder #(
    parameter int unsigned NCORES = hsa_pkg::DEF_CORES,
    localparam int unsigned IDXW  = $clog2(NCORES)
) (
    input  logic [NCORES-1:0] active_i,
    output logic [IDXW-1:0]   top_o,
    output logic              any_o
);
    // Scan upward; the last set bit seen is the highest one.
    always_comb begin
        top_o = '0;
        for (int i = 0; i < NCORES; i++) begin
            if (active_i[i]) top_o = IDXW'(i);
        end
    end

    assign any_o = |active_i;
endmodule

// File: rtl/hsa_rotation_ctl.sv
module hsa_rotation_ctl
    import hsa_pkg::*;
#(
    parameter int unsigned NCORES = DEF_CORES,
    localparam int unsigned IDXW  = $clog2(NCORES),
    localparam logic [IDXW-1:0] LAST_SLOT = IDXW'(NCORES - 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable_i,
    input  logic [IDXW-1:0] top_i,
    output logic [IDXW-1:0] slot_o,
    output logic [IDXW-1:0] limit_o,
    output rot_mode_e       mode_o
);
    logic [IDXW-1:0] slot_q;
    rot_mode_e       mode_q;
    logic            wrap;

    // The rotation in progress uses the latched mode but the live top.
    assign limit_o = (mode_q == ROT_TOP) ? top_i : LAST_SLOT;

    // Using >= lets a count stranded above a lowered top wrap at once.
    assign wrap = (slot_q >= limit_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            mode_q <= ROT_FIXED;
        end else if (wrap) begin
            slot_q <= '0;
            mode_q <= mode_from_flag(enable_i);
        end else begin
            slot_q <= slot_q + 1'b1;
        end
    end

    assign slot_o = slot_q;
    assign mode_o = mode_q;
endmodule

// File: rtl/hsa_grant_gate.sv
module hsa_grant_gate #(
    parameter int unsigned NCORES = hsa_pkg::DEF_CORES,
    localparam int unsigned IDXW  = $clog2(NCORES)
) (
    input  logic [IDXW-1:0] slot_i,
    input  logic [IDXW-1:0] limit_i,
    input  logic            any_i,
    output logic            valid_o
);
    assign valid_o = any_i && (slot_i <= limit_i);
endmodule

// File: rtl/hub_topcore_arbiter.sv
module hub_topcore_arbiter
    import hsa_pkg::*;
#(
    parameter int unsigned NCORES = DEF_CORES,
    localparam int unsigned IDXW  = $clog2(NCORES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCORES-1:0] active_i,
    input  logic              enable_i,
    output logic [IDXW-1:0]   grant_idx_o,
    output logic              grant_valid_o
);
    logic [IDXW-1:0] top_idx;
    logic            any_active;
    logic [IDXW-1:0] slot;
    logic [IDXW-1:0] limit;
    rot_mode_e       rot_mode;
    logic            dyn_mode;

    hsa_top_encoder #(.NCORES(NCORES)) u_enc (
        .active_i (active_i),
        .top_o    (top_idx),
        .any_o    (any_active)
    );

    hsa_rotation_ctl #(.NCORES(NCORES)) u_rot (
        .clk      (clk),
        .rst      (rst),
        .enable_i (enable_i),
        .top_i    (top_idx),
        .slot_o   (slot),
        .limit_o  (limit),
        .mode_o   (rot_mode)
    );

    hsa_grant_gate #(.NCORES(NCORES)) u_gate (
        .slot_i  (slot),
        .limit_i (limit),
        .any_i   (any_active),
        .valid_o (grant_valid_o)
    );

    assign grant_idx_o = slot;
    assign dyn_mode    = (rot_mode == ROT_TOP);
endmodule

// File: rtl/hub_topcore_arbiter_chk.sv
module hub_topcore_arbiter_chk #(
    parameter int unsigned NCORES = hsa_pkg::DEF_CORES,
    localparam int unsigned IDXW  = $clog2(NCORES),
    localparam logic [IDXW-1:0] LAST = IDXW'(NCORES - 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [NCORES-1:0] active_i,
    input logic [IDXW-1:0]   grant_idx_o,
    input logic              grant_valid_o,
    input logic              dyn_mode
);
    AST_RESET_SLOT0: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (grant_idx_o == '0 && !dyn_mode)); // R1

    AST_FIXED_STEP: assert property (@(posedge clk) disable iff (rst)
        (!dyn_mode && grant_idx_o != LAST) |=> grant_idx_o == $past(grant_idx_o) + 1'b1); // R2

    AST_FIXED_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!dyn_mode && grant_idx_o == LAST) |=> grant_idx_o == '0); // R2

    AST_TOP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (dyn_mode && (active_i >> grant_idx_o) == NCORES'(1)) |=> grant_idx_o == '0); // R3

    AST_BEYOND_TOP_LOW: assert property (@(posedge clk) disable iff (rst)
        (dyn_mode && (active_i >> grant_idx_o) == '0) |-> !grant_valid_o); // R5

    AST_BEYOND_TOP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (dyn_mode && (active_i >> grant_idx_o) == '0) |=> grant_idx_o == '0); // R5

    AST_MODE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        !$stable(dyn_mode) |-> grant_idx_o == '0); // R6

    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        (active_i == '0) |-> !grant_valid_o); // R7

    AST_FIXED_VALID: assert property (@(posedge clk) disable iff (rst)
        (!dyn_mode && active_i != '0) |-> grant_valid_o); // R8
endmodule

bind hub_topcore_arbiter hub_topcore_arbiter_chk #(.NCORES(NCORES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .active_i      (active_i),
    .grant_idx_o   (grant_idx_o),
    .grant_valid_o (grant_valid_o),
    .dyn_mode      (dyn_mode)
);

// File: tb/tb_hub_topcore_arbiter.sv
`timescale 1ns/1ps
module tb_hub_topcore_arbiter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] active_i = '0;
    logic        enable_i = 1'b0;
    logic [3:0]  grant_idx_o;
    logic        grant_valid_o;
    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hub_topcore_arbiter dut (
        .clk(clk), .rst(rst), .active_i(active_i), .enable_i(enable_i),
        .grant_idx_o(grant_idx_o), .grant_valid_o(grant_valid_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_slot0();
        for (int i = 0; i < 40 && grant_idx_o != 0; i++) tick();
    endtask

    task automatic t_reset();
        repeat (3) tick();
        chk("R1 idx in reset", grant_idx_o, 0);
        chk("R7 valid in reset, idle", grant_valid_o, 0);
        active_i = 16'h0001;
        rst = 1'b0;
        #1 chk("R1 idx after release", grant_idx_o, 0);
    endtask

    task automatic t_fixed();
        for (int k = 1; k <= 32; k++) begin
            tick();
            chk("R2 fixed idx", grant_idx_o, k % 16);
            chk("R8 fixed valid", grant_valid_o, 1);
            if (k == 5) active_i = 16'h0003;
        end
    endtask

    task automatic t_enable_deferred();
        wait_slot0();
        enable_i = 1'b1;
        active_i = 16'h0011;
        for (int k = 1; k <= 15; k++) begin
            tick();
            chk("R6 enable waits for wrap", grant_idx_o, k);
        end
        tick();
        chk("R6 wrap", grant_idx_o, 0);
        for (int r = 0; r < 2; r++) begin
            for (int k = 1; k <= 4; k++) begin
                tick();
                chk("R3 len5", grant_idx_o, k);
            end
            tick();
            chk("R3 len5 wrap", grant_idx_o, 0);
        end
    endtask

    task automatic run_len(input logic [15:0] act, input int top, input string req);
        active_i = act;
        for (int r = 0; r < 2; r++) begin
            for (int k = 1; k <= top; k++) begin
                tick();
                chk(req, grant_idx_o, k);
                chk("R8 valid in rotation", grant_valid_o, 1);
            end
            tick();
            chk(req, grant_idx_o, 0);
        end
    endtask

    task automatic t_lower_top();
        active_i = 16'h8001;
        repeat (10) tick();
        chk("R5 reached slot 10", grant_idx_o, 10);
        active_i = 16'h0009;
        #1 chk("R5 valid low above top", grant_valid_o, 0);
        tick();
        chk("R5 wrap next clock", grant_idx_o, 0);
        chk("R5 valid back", grant_valid_o, 1);
        for (int k = 1; k <= 3; k++) begin
            tick();
            chk("R5 new length 4", grant_idx_o, k);
        end
        tick();
        chk("R5 new wrap", grant_idx_o, 0);
    endtask

    task automatic t_idle_dyn();
        active_i = '0;
        #1 chk("R7 idle dyn valid", grant_valid_o, 0);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R7 idle dyn idx", grant_idx_o, 0);
            chk("R7 idle dyn valid", grant_valid_o, 0);
        end
    endtask

    task automatic t_disable_deferred();
        active_i = 16'h0011;
        tick(); tick();
        chk("R6 at slot 2", grant_idx_o, 2);
        enable_i = 1'b0;
        tick(); chk("R6 short rotation kept", grant_idx_o, 3);
        tick(); chk("R6 short rotation kept", grant_idx_o, 4);
        tick(); chk("R6 wraps at old top", grant_idx_o, 0);
        for (int k = 1; k <= 15; k++) begin
            tick();
            chk("R6 fixed after wrap", grant_idx_o, k);
        end
        tick();
        chk("R6 fixed wrap", grant_idx_o, 0);
    endtask

    task automatic t_idle_fixed();
        active_i = '0;
        for (int k = 1; k <= 5; k++) begin
            tick();
            chk("R7 idle fixed idx", grant_idx_o, k);
            chk("R7 idle fixed valid", grant_valid_o, 0);
        end
    endtask

    initial begin
        t_reset();
        t_fixed();
        t_enable_deferred();
        run_len(16'h0004, 2, "R3 len3");
        run_len(16'h0001, 0, "R3 len1");
        run_len(16'h0021, 5, "R3 len6");
        run_len(16'h0041, 6, "R3 len7");
        run_len(16'h0080, 7, "R4 len8");
        run_len(16'h0250, 9, "R3 len10");
        run_len(16'h4001, 14, "R3 len15");
        run_len(16'h8000, 15, "R4 len16");
        run_len(16'h0008, 3, "R3 len4");
        t_lower_top();
        t_idle_dyn();
        t_disable_deferred();
        t_idle_fixed();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got 0 expected 1 (run completed)");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule